// File: doc/BRIEF.md
# Private-Cache MSI Line Controller

This block is the processor-side coherence agent for one coherence unit of one word. It sits between a processor and a point-to-point network in a directory-based invalidation system. The block keeps the line in one of three stable states: Invalid, Shared (read-only) or Modified (dirty and exclusive). It also tracks the transient states a request passes through before it completes.

The processor issues load, store and eviction operations. The block answers each one with a one-cycle done pulse, and with read data for loads. While an operation waits on the network, the block reports stall.

Towards the network there are three send ports: requests to the home node, responses to another node, and a data copy to the home node. There are also two receive ports, one for forwarded requests from the home and one for responses. Each receive port is a single slot. A message stays in its slot until the block consumes it with the take strobe. Messages may arrive in any order, so the block must handle races. Examples are an invalidation that overtakes the data it is waiting for, acknowledgements that arrive before the data reply, and a forward that reaches the block before its own ownership is complete.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid, and cpu_stall, cpu_done and every send valid are low.
- R2: A load in Invalid sends a read request (request type 0) and raises cpu_stall. A data response (response type 0) completes the load with that data and leaves the line Shared.
- R3: In Shared or Modified, a load completes with the held word and sends nothing. In Modified, a store writes the word and completes the same way.
- R4: A store in Invalid or Shared sends an ownership request (request type 1). It completes only after two conditions hold: the data response has arrived, and the number of acknowledgements (response type 1) received equals the count in that data response's ack field. Acknowledgements may arrive before or after the data. The line then becomes Modified and holds the store value.
- R5: Evicting a Shared line drops it to Invalid and completes with no message sent. Evicting an Invalid line completes with no message.
- R6: Evicting a Modified line sends a write-back (request type 2) carrying the word. The operation stays stalled until a write-back acknowledgement (response type 2) arrives, and the line then ends Invalid.
- R7: A forwarded read (forward type 0) in Modified sends a data response (type 0) carrying the word to the forward's source node. It also sends the word to the home node, and the line becomes Shared.
- R8: A forwarded ownership request (forward type 1) in Modified sends the word to the source node as a data response, and the line becomes Invalid.
- R9: An invalidation (forward type 2) in Shared or Invalid is answered with an acknowledgement (response type 1) addressed to the forward's source node. The line ends Invalid.
- R10: An invalidation that arrives while a load miss waits for data is acknowledged at once. The data that follows completes the load with its value, and the line ends Invalid.
- R11: Forwarded reads and ownership requests are not taken while a store waits for ownership; they are served after it completes. An invalidation taken before the store's data arrives is acknowledged, and the store still completes.
- R12: A forward taken while a write-back is outstanding is served from the written-back word, with the same messages as in Modified. The later write-back acknowledgement completes the eviction and leaves the line Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor operation strobe |
| cpu_req_op | input | 2 | 0 load, 1 store, 2 eviction |
| cpu_wdata | input | DATA_W | Store value |
| cpu_stall | output | 1 | An operation is waiting on the network |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result |
| req_out_valid | output | 1 | Request to home valid |
| req_out_type | output | 2 | 0 read, 1 ownership, 2 write-back |
| req_out_data | output | DATA_W | Write-back data |
| fwd_in_valid | input | 1 | Forward slot occupied |
| fwd_in_type | input | 2 | 0 forwarded read, 1 forwarded ownership, 2 invalidation |
| fwd_in_src | input | NODE_W | Node that wants the line |
| fwd_take | output | 1 | Forward slot consumed this cycle |
| rsp_in_valid | input | 1 | Response slot occupied |
| rsp_in_type | input | 2 | 0 data, 1 ack, 2 write-back ack |
| rsp_in_acks | input | ACK_W | Acks to expect, carried by data |
| rsp_in_data | input | DATA_W | Data word |
| rsp_take | output | 1 | Response slot consumed this cycle |
| rsp_out_valid | output | 1 | Response to a node valid |
| rsp_out_type | output | 2 | 0 data, 1 ack |
| rsp_out_dst | output | NODE_W | Destination node |
| rsp_out_data | output | DATA_W | Data word |
| home_out_valid | output | 1 | Data copy to home valid |
| home_out_data | output | DATA_W | Data copy |

## Verification
The assertions assume a well-behaved directory and processor. The processor issues operations only while cpu_stall is low. A data reply never promises fewer acknowledgements than later arrive. Forwarded reads and ownership requests reach the block only once the directory has recorded it as owner. The stimulus follows the message sequence a directory would produce for each scenario. It holds every message in its slot until the block takes it, and it never delivers more acknowledgements than the data reply announced.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [3:0] {
    ST_I, ST_S, ST_M,
    ST_IS_D, ST_IS_DI,
    ST_SM_W, ST_IM_W,
    ST_MI_A, ST_SI_A, ST_II_A
  } line_st_e;

  localparam logic [1:0] OP_LD = 2'd0;
  localparam logic [1:0] OP_ST = 2'd1;
  localparam logic [1:0] OP_EV = 2'd2;

  localparam logic [1:0] RQ_GETS = 2'd0;
  localparam logic [1:0] RQ_GETM = 2'd1;
  localparam logic [1:0] RQ_PUTM = 2'd2;

  localparam logic [1:0] FW_GETS = 2'd0;
  localparam logic [1:0] FW_GETM = 2'd1;
  localparam logic [1:0] FW_INV  = 2'd2;

  localparam logic [1:0] RS_DATA   = 2'd0;
  localparam logic [1:0] RS_ACK    = 2'd1;
  localparam logic [1:0] RS_PUTACK = 2'd2;
endpackage

// File: rtl/msi_ack_track.sv
module msi_ack_track #(
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             data_fire,
  input  logic [ACK_W-1:0] data_need,
  input  logic             ack_fire,
  output logic             complete
);
  logic             have_data;
  logic [ACK_W-1:0] need_q;
  logic [ACK_W-1:0] got_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      have_data <= 1'b0;
      need_q    <= '0;
      got_q     <= '0;
    end else begin
      if (data_fire) begin
        have_data <= 1'b1;
        need_q    <= data_need;
      end
      if (ack_fire) got_q <= got_q + 1'b1;
    end
  end

  assign complete = have_data && (got_q == need_q);

  // R4
  ack_bound_chk: assert property (@(posedge clk) disable iff (rst)
    have_data |-> (got_q <= need_q));
endmodule

// File: rtl/msi_tx_reg.sv
module msi_tx_reg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [PW-1:0] payload,
  output logic          valid,
  output logic [PW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      valid <= fire;
      if (fire) q <= payload;
    end
  end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NODE_W = 2,
  parameter int ACK_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic [1:0]        cpu_req_op,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              req_out_valid,
  output logic [1:0]        req_out_type,
  output logic [DATA_W-1:0] req_out_data,
  input  logic              fwd_in_valid,
  input  logic [1:0]        fwd_in_type,
  input  logic [NODE_W-1:0] fwd_in_src,
  output logic              fwd_take,
  input  logic              rsp_in_valid,
  input  logic [1:0]        rsp_in_type,
  input  logic [ACK_W-1:0]  rsp_in_acks,
  input  logic [DATA_W-1:0] rsp_in_data,
  output logic              rsp_take,
  output logic              rsp_out_valid,
  output logic [1:0]        rsp_out_type,
  output logic [NODE_W-1:0] rsp_out_dst,
  output logic [DATA_W-1:0] rsp_out_data,
  output logic              home_out_valid,
  output logic [DATA_W-1:0] home_out_data
);
  localparam int REQ_PW = 2 + DATA_W;
  localparam int RSP_PW = 2 + NODE_W + DATA_W;

  line_st_e          state, state_nx;
  logic [DATA_W-1:0] word, word_nx, pend_wd, pend_nx, rdata_nx;
  logic              done_nx;
  logic              req_fire, rsp_fire, home_fire;
  logic [1:0]        req_type, rsp_type;
  logic [NODE_W-1:0] rsp_dst;
  logic [DATA_W-1:0] rsp_data;
  logic              trk_clr, trk_data, trk_ack, trk_complete;
  logic              stable, waiting_own, cpu_acc, own_done, rsp_go, fwd_ok, fwd_go;

  assign stable      = (state == ST_I) || (state == ST_S) || (state == ST_M);
  assign waiting_own = (state == ST_SM_W) || (state == ST_IM_W);
  assign cpu_acc     = cpu_req_valid && stable;
  assign own_done    = waiting_own && trk_complete;
  assign rsp_go      = !cpu_acc && !own_done && rsp_in_valid;

  always_comb begin
    if (fwd_in_type == FW_INV) fwd_ok = (state != ST_IM_W) && (state != ST_M) && (state != ST_MI_A);
    else                       fwd_ok = (state == ST_M) || (state == ST_MI_A);
  end
  assign fwd_go   = !cpu_acc && !own_done && !rsp_in_valid && fwd_in_valid && fwd_ok;
  assign rsp_take = rsp_go;
  assign fwd_take = fwd_go;

  always_comb begin
    state_nx = state;   word_nx  = word;   pend_nx  = pend_wd;
    done_nx  = 1'b0;    rdata_nx = cpu_rdata;
    req_fire = 1'b0;    req_type = RQ_GETS;
    rsp_fire = 1'b0;    rsp_type = RS_DATA; rsp_dst = fwd_in_src; rsp_data = word;
    home_fire = 1'b0;
    trk_clr = 1'b0;     trk_data = 1'b0;    trk_ack = 1'b0;
    if (cpu_acc) begin
      case (state)
        ST_I: begin
          if (cpu_req_op == OP_LD) begin
            req_fire = 1'b1; req_type = RQ_GETS; state_nx = ST_IS_D;
          end else if (cpu_req_op == OP_ST) begin
            req_fire = 1'b1; req_type = RQ_GETM; pend_nx = cpu_wdata;
            trk_clr = 1'b1;  state_nx = ST_IM_W;
          end else done_nx = 1'b1;
        end
        ST_S: begin
          if (cpu_req_op == OP_LD) begin
            done_nx = 1'b1; rdata_nx = word;
          end else if (cpu_req_op == OP_ST) begin
            req_fire = 1'b1; req_type = RQ_GETM; pend_nx = cpu_wdata;
            trk_clr = 1'b1;  state_nx = ST_SM_W;
          end else begin
            done_nx = 1'b1; state_nx = ST_I;
          end
        end
        default: begin
          if (cpu_req_op == OP_LD) begin
            done_nx = 1'b1; rdata_nx = word;
          end else if (cpu_req_op == OP_ST) begin
            done_nx = 1'b1; word_nx = cpu_wdata;
          end else begin
            req_fire = 1'b1; req_type = RQ_PUTM; state_nx = ST_MI_A;
          end
        end
      endcase
    end else if (own_done) begin
      word_nx = pend_wd; done_nx = 1'b1; state_nx = ST_M;
    end else if (rsp_go) begin
      if (rsp_in_type == RS_DATA) begin
        if (state == ST_IS_D) begin
          word_nx = rsp_in_data; rdata_nx = rsp_in_data; done_nx = 1'b1; state_nx = ST_S;
        end else if (state == ST_IS_DI) begin
          rdata_nx = rsp_in_data; done_nx = 1'b1; state_nx = ST_I;
        end else if (waiting_own) trk_data = 1'b1;
      end else if (rsp_in_type == RS_ACK) begin
        if (waiting_own) trk_ack = 1'b1;
      end else if (rsp_in_type == RS_PUTACK) begin
        if ((state == ST_MI_A) || (state == ST_SI_A) || (state == ST_II_A)) begin
          done_nx = 1'b1; state_nx = ST_I;
        end
      end
    end else if (fwd_go) begin
      rsp_fire = 1'b1;
      if (fwd_in_type == FW_INV) begin
        rsp_type = RS_ACK;
        case (state)
          ST_S:    state_nx = ST_I;
          ST_IS_D: state_nx = ST_IS_DI;
          ST_SM_W: state_nx = ST_IM_W;
          ST_SI_A: state_nx = ST_II_A;
          default: state_nx = state;
        endcase
      end else if (fwd_in_type == FW_GETS) begin
        home_fire = 1'b1;
        state_nx  = (state == ST_M) ? ST_S : ST_SI_A;
      end else begin
        state_nx  = (state == ST_M) ? ST_I : ST_II_A;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_I;
      word      <= '0;
      pend_wd   <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      cpu_stall <= 1'b0;
    end else begin
      state     <= state_nx;
      word      <= word_nx;
      pend_wd   <= pend_nx;
      cpu_done  <= done_nx;
      cpu_rdata <= rdata_nx;
      cpu_stall <= !((state_nx == ST_I) || (state_nx == ST_S) || (state_nx == ST_M));
    end
  end

  msi_ack_track #(.ACK_W(ACK_W)) u_acks (
    .clk(clk), .rst(rst), .clr(trk_clr), .data_fire(trk_data),
    .data_need(rsp_in_acks), .ack_fire(trk_ack), .complete(trk_complete));

  msi_tx_reg #(.PW(REQ_PW)) u_req_tx (
    .clk(clk), .rst(rst), .fire(req_fire), .payload({req_type, word}),
    .valid(req_out_valid), .q({req_out_type, req_out_data}));

  msi_tx_reg #(.PW(RSP_PW)) u_rsp_tx (
    .clk(clk), .rst(rst), .fire(rsp_fire), .payload({rsp_type, rsp_dst, rsp_data}),
    .valid(rsp_out_valid), .q({rsp_out_type, rsp_out_dst, rsp_out_data}));

  msi_tx_reg #(.PW(DATA_W)) u_home_tx (
    .clk(clk), .rst(rst), .fire(home_fire), .payload(word),
    .valid(home_out_valid), .q(home_out_data));

  // R7
  home_copy_chk: assert property (@(posedge clk) disable iff (rst)
    home_out_valid |-> (rsp_out_valid && rsp_out_type == RS_DATA && rsp_out_data == home_out_data));
  // R8
  owner_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_out_valid && rsp_out_type == RS_DATA) |-> ($past(state) == ST_M || $past(state) == ST_MI_A));
  // R6
  putm_chk: assert property (@(posedge clk) disable iff (rst)
    (req_out_valid && req_out_type == RQ_PUTM) |-> (state == ST_MI_A || state == ST_SI_A || state == ST_II_A));
  // R3
  done_stable_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> (state == ST_I || state == ST_S || state == ST_M));
  // R11
  slot_take_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_take |-> fwd_in_valid) and (rsp_take |-> rsp_in_valid) and !(fwd_take && rsp_take));
endmodule

// File: tb/test_msi_line_ctrl.sv
module test_msi_line_ctrl;
  localparam int DW = 8, NW = 2, AW = 2;
  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req_valid = 0; logic [1:0] cpu_req_op = 0; logic [DW-1:0] cpu_wdata = 0;
  logic cpu_stall, cpu_done; logic [DW-1:0] cpu_rdata;
  logic req_out_valid; logic [1:0] req_out_type; logic [DW-1:0] req_out_data;
  logic fwd_in_valid = 0; logic [1:0] fwd_in_type = 0; logic [NW-1:0] fwd_in_src = 0; logic fwd_take;
  logic rsp_in_valid = 0; logic [1:0] rsp_in_type = 0; logic [AW-1:0] rsp_in_acks = 0;
  logic [DW-1:0] rsp_in_data = 0; logic rsp_take;
  logic rsp_out_valid; logic [1:0] rsp_out_type; logic [NW-1:0] rsp_out_dst; logic [DW-1:0] rsp_out_data;
  logic home_out_valid; logic [DW-1:0] home_out_data;

  always #5 clk = ~clk;

  msi_line_ctrl #(.DATA_W(DW), .NODE_W(NW), .ACK_W(AW)) i_msi_line_ctrl (.*);

  int n_chk = 0, n_bad = 0;
  int req_n = 0, rsp_n = 0, home_n = 0, done_n = 0, fwd_n = 0;
  int req_t = 0, req_d = 0, rsp_t = 0, rsp_dst = 0, rsp_d = 0, home_d = 0, rd = 0;

  always @(posedge clk) begin
    if (req_out_valid === 1'b1) begin req_n <= req_n + 1; req_t <= req_out_type; req_d <= req_out_data; end
    if (rsp_out_valid === 1'b1) begin rsp_n <= rsp_n + 1; rsp_t <= rsp_out_type; rsp_dst <= rsp_out_dst; rsp_d <= rsp_out_data; end
    if (home_out_valid === 1'b1) begin home_n <= home_n + 1; home_d <= home_out_data; end
    if (cpu_done === 1'b1) begin done_n <= done_n + 1; rd <= cpu_rdata; end
    if (fwd_in_valid && fwd_take === 1'b1) fwd_n <= fwd_n + 1;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic cpu_issue(logic [1:0] op, int wd);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_op = op; cpu_wdata = wd[DW-1:0];
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic wait_done(int n0);
    for (int i = 0; i < 40 && done_n <= n0; i++) @(negedge clk);
  endtask

  task automatic give_rsp(logic [1:0] t, int acks, int d);
    bit tk;
    @(negedge clk);
    rsp_in_valid = 1'b1; rsp_in_type = t; rsp_in_acks = acks[AW-1:0]; rsp_in_data = d[DW-1:0];
    do begin
      #1 tk = rsp_take;
      @(posedge clk);
      if (!tk) @(negedge clk);
    end while (!tk);
    #1 rsp_in_valid = 1'b0;
  endtask

  task automatic give_fwd(logic [1:0] t, int src);
    bit tk;
    @(negedge clk);
    fwd_in_valid = 1'b1; fwd_in_type = t; fwd_in_src = src[NW-1:0];
    do begin
      #1 tk = fwd_take;
      @(posedge clk);
      if (!tk) @(negedge clk);
    end while (!tk);
    #1 fwd_in_valid = 1'b0;
  endtask

  // I -> M holding value d (store miss, no sharers)
  task automatic to_m(int d);
    int n0 = done_n;
    cpu_issue(1, d); settle();
    give_rsp(0, 0, 8'hEE); wait_done(n0);
  endtask

  // M -> I through write-back
  task automatic evict_m(string tag, int d);
    int n0 = done_n, r0 = req_n;
    cpu_issue(2, 0); settle();
    chk({tag, " putm sent"}, req_n, r0 + 1);
    chk({tag, " putm type"}, req_t, 2);
    chk({tag, " putm data"}, req_d, d);
    chk({tag, " stall until putack"}, done_n, n0);
    give_rsp(2, 0, 0); wait_done(n0);
    chk({tag, " evict done"}, done_n, n0 + 1);
  endtask

  // load from I: expect read request; supply data d
  task automatic load_miss(string tag, int d);
    int n0 = done_n, r0 = req_n;
    cpu_issue(0, 0); settle();
    chk({tag, " gets sent"}, req_n, r0 + 1);
    chk({tag, " gets type"}, req_t, 0);
    give_rsp(0, 0, d); wait_done(n0);
    chk({tag, " load data"}, rd, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n0, r0, s0, h0, f0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 stall", cpu_stall, 0);
    chk("R1 done", cpu_done, 0);
    chk("R1 sends", req_out_valid + rsp_out_valid + home_out_valid, 0);

    // R2 / R3: load miss sweep then hits
    for (int v = 0; v < 4; v++) begin
      r0 = req_n;
      load_miss("R2", 8'h11 * (v + 1));
      cpu_issue(0, 0); settle();
      chk("R3 S-hit data", rd, 8'h11 * (v + 1));
      chk("R3 S-hit no msg", req_n, r0 + 1);
      n0 = done_n;
      cpu_issue(2, 0); settle();
      chk("R5 S-evict done", done_n, n0 + 1);
      chk("R5 S-evict no msg", req_n, r0 + 1);
    end
    n0 = done_n; r0 = req_n;
    cpu_issue(2, 0); settle();
    chk("R5 I-evict done", done_n, n0 + 1);
    chk("R5 I-evict no msg", req_n, r0);

    // R4 sweep over ack counts and arrival split
    for (int need = 0; need < 4; need++) begin
      for (int pre = 0; pre <= need; pre++) begin
        int d = need * 16 + pre * 4 + 1;
        n0 = done_n; r0 = req_n;
        cpu_issue(1, d); settle();
        chk("R4 getm sent", req_n, r0 + 1);
        chk("R4 getm type", req_t, 1);
        chk("R4 stall", cpu_stall, 1);
        for (int k = 0; k < pre; k++) give_rsp(1, 0, 0);
        settle();
        chk("R4 not done before data", done_n, n0);
        give_rsp(0, need, 8'h5A);
        if (need > pre) begin
          settle();
          chk("R4 not done before acks", done_n, n0);
        end
        for (int k = 0; k < need - pre; k++) give_rsp(1, 0, 0);
        wait_done(n0);
        chk("R4 done", done_n, n0 + 1);
        cpu_issue(0, 0); settle();
        chk("R4 M-hit data", rd, d);
        cpu_issue(1, d + 128); settle();
        cpu_issue(0, 0); settle();
        chk("R3 M-store data", rd, d + 128);
        evict_m("R6", d + 128);
      end
    end

    // R4 store from Shared
    load_miss("R4 pre", 8'h21);
    n0 = done_n; r0 = req_n;
    cpu_issue(1, 8'h42); settle();
    chk("R4 S-store getm", req_t, 1);
    give_rsp(0, 1, 8'h21); give_rsp(1, 0, 0); wait_done(n0);
    cpu_issue(0, 0); settle();
    chk("R4 S-store data", rd, 8'h42);

    // R7 forwarded read in M
    s0 = rsp_n; h0 = home_n; r0 = req_n;
    give_fwd(0, 2); settle();
    chk("R7 data sent", rsp_n, s0 + 1);
    chk("R7 type", rsp_t, 0);
    chk("R7 dst", rsp_dst, 2);
    chk("R7 data", rsp_d, 8'h42);
    chk("R7 home copy", home_n, h0 + 1);
    chk("R7 home data", home_d, 8'h42);
    cpu_issue(0, 0); settle();
    chk("R7 shared hit", rd, 8'h42);
    chk("R7 shared no msg", req_n, r0);

    // R9 invalidation in S then in I
    s0 = rsp_n;
    give_fwd(2, 1); settle();
    chk("R9 ack sent", rsp_n, s0 + 1);
    chk("R9 ack type", rsp_t, 1);
    chk("R9 ack dst", rsp_dst, 1);
    give_fwd(2, 3); settle();
    chk("R9 I ack dst", rsp_dst, 3);
    load_miss("R9 now I", 8'h31);
    cpu_issue(2, 0); settle();

    // R8 forwarded ownership in M
    to_m(8'h66);
    s0 = rsp_n; h0 = home_n;
    give_fwd(1, 3); settle();
    chk("R8 data dst", rsp_dst, 3);
    chk("R8 data", rsp_d, 8'h66);
    chk("R8 no home copy", home_n, h0);
    load_miss("R8 now I", 8'h67);
    cpu_issue(2, 0); settle();

    // R10 invalidation overtakes load data
    n0 = done_n; r0 = req_n; s0 = rsp_n;
    cpu_issue(0, 0); settle();
    give_fwd(2, 3); settle();
    chk("R10 early ack", rsp_n, s0 + 1);
    chk("R10 ack dst", rsp_dst, 3);
    give_rsp(0, 0, 8'h9C); wait_done(n0);
    chk("R10 load data", rd, 8'h9C);
    load_miss("R10 ends I", 8'h9D);
    cpu_issue(2, 0); settle();

    // R11 forward held back while ownership pending
    n0 = done_n; s0 = rsp_n; f0 = fwd_n;
    cpu_issue(1, 8'h77); settle();
    give_rsp(0, 1, 0);
    @(negedge clk);
    fwd_in_valid = 1'b1; fwd_in_type = 2'd0; fwd_in_src = 2'd2;
    repeat (4) @(negedge clk);
    chk("R11 fwd held", fwd_n, f0);
    chk("R11 no send", rsp_n, s0);
    give_rsp(1, 0, 0);
    for (int i = 0; i < 20 && fwd_n == f0; i++) @(negedge clk);
    fwd_in_valid = 1'b0;
    settle();
    chk("R11 store done", done_n, n0 + 1);
    chk("R11 fwd served dst", rsp_dst, 2);
    chk("R11 fwd served data", rsp_d, 8'h77);
    chk("R11 home data", home_d, 8'h77);
    // R11 invalidation before data while upgrading from S
    n0 = done_n; s0 = rsp_n;
    cpu_issue(1, 8'h78); settle();
    give_fwd(2, 1); settle();
    chk("R11 inv acked", rsp_n, s0 + 1);
    give_rsp(0, 0, 8'h77); wait_done(n0);
    cpu_issue(0, 0); settle();
    chk("R11 store after inv", rd, 8'h78);

    // R12 forward during write-back
    n0 = done_n; s0 = rsp_n;
    cpu_issue(2, 0); settle();
    give_fwd(0, 1); settle();
    chk("R12 data dst", rsp_dst, 1);
    chk("R12 data", rsp_d, 8'h78);
    chk("R12 home data", home_d, 8'h78);
    chk("R12 still stalled", done_n, n0);
    give_rsp(2, 0, 0); wait_done(n0);
    chk("R12 evict done", done_n, n0 + 1);
    load_miss("R12 ends I", 8'hA5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule